// File: doc/BRIEF.md
# Ratio-Controlled Two-Input Audio Mixer

This block merges two mono sample streams into a single mono stream. Samples arrive as 16-bit unsigned amplitudes, where 0 is silence and 65535 is full scale. They come over a one-way input link with data, valid and ready signals. Each frame on that link is a pair of words: the first belongs to channel 1 and the second to channel 2. Before the two samples are combined, each is multiplied by its own mixing percentage and divided by 50. A percentage of 50 is unity gain, a smaller value attenuates and a larger value boosts.

The two gained samples are combined as a + b − ((a·b) >> 16). This non-linear sum stays at or above the louder input, but it does not add the two levels linearly. The result is clamped to full scale. It leaves on a separate one-way output link as two identical words, one for each of the left and right slots.

Software can rewrite either percentage at any time while audio flows, through a small write port. A new value is used from the next frame that starts.

Top module: `ratio_audio_mixer`

## Requirements
- R1: After reset, `outValid` is 0, `inReady` is 1, any half-collected frame is discarded, and both percentages are 50 (unity gain).
- R2: The first word accepted in a frame is channel 1 and the second is channel 2. No output word is offered until both have been accepted.
- R3: Each channel is gained as floor(sample × pct / 50). Any gained value above 65535 is clamped to 65535.
- R4: The mix of gained samples a and b is a + b − ((a × b) >> 16), clamped to 65535.
- R5: Each frame produces exactly two output words with identical data (left slot first, then right slot).
- R6: While `outValid` is 1 and `outReady` is 0, `outValid` and `outData` hold. `inReady` stays 0 until both output words have been taken, so no result is dropped.
- R7: A write on the percentage port (`pctWrSel` 0 selects channel 1, 1 selects channel 2) stores values above 100 as 100.
- R8: A percentage write that lands between the two words of a frame does not affect that frame. It applies from the next frame on, and the stream continues without a reset.
- R9: `outValid` rises in the clock cycle right after the channel 2 word is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| inData | input | 16 | Input sample word (channel 1, then channel 2) |
| inValid | input | 1 | Input word present |
| inReady | output | 1 | Block can take an input word |
| outData | output | 16 | Mixed sample word |
| outValid | output | 1 | Output word present |
| outReady | input | 1 | Downstream takes the output word |
| pctWrEn | input | 1 | Percentage write strobe |
| pctWrSel | input | 1 | Channel selected for the write (0 = channel 1, 1 = channel 2) |
| pctWrData | input | 8 | Percentage value to write; values above 100 are clamped |

## Verification
The bench targets the following corner cases, each paired with the failure it would expose:
- Both inputs at full scale, where the unclamped formula gives 65536. A missing clamp would wrap the result to 0.
- A boost to 100% of a large sample. Without the gain clamp the gained value would overflow and the output would come out quiet.
- Percentages of 0, and a zero sample on one side. A wrong cross term would leak the silent channel into the result or reduce the live one.
- A write of 200. Without clamping this would double the gain.
- A percentage write between the two words of a frame. A design that reads the live register would change the current frame's result.
- Long output stalls. A design with weak handshaking would let its data drift, accept a new frame early, or emit only one word.

// File: rtl/mixer_pkg.sv
package mixer_pkg;

  typedef enum logic [1:0] {
    ST_FIRST  = 2'd0,
    ST_SECOND = 2'd1,
    ST_EMIT_L = 2'd2,
    ST_EMIT_R = 2'd3
  } mixState_t;

  typedef struct packed {
    logic takeFirst;
    logic takeSecond;
  } mixStrobes_t;

endpackage

// File: rtl/mix_scaler.sv
module mix_scaler #(
  parameter int SAMPLE_W  = 16,
  parameter int PCT_W     = 7,
  parameter int PCT_UNITY = 50
) (
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic [PCT_W-1:0]    pctIn,
  output logic [SAMPLE_W-1:0] scaledOut
);
  localparam int PROD_W = SAMPLE_W + PCT_W;
  localparam logic [PROD_W-1:0] FULL = PROD_W'({SAMPLE_W{1'b1}});

  logic [PROD_W-1:0] product;
  logic [PROD_W-1:0] quotient;

  always_comb begin
    product   = PROD_W'(sampleIn) * PROD_W'(pctIn);
    quotient  = product / PROD_W'(PCT_UNITY);
    scaledOut = (quotient > FULL) ? {SAMPLE_W{1'b1}} : quotient[SAMPLE_W-1:0];
  end
endmodule

// File: rtl/mix_control.sv
module mix_control
  import mixer_pkg::*;
#(
  parameter int PCT_W     = 7,
  parameter int CFG_W     = 8,
  parameter int PCT_MAX   = 100,
  parameter int PCT_UNITY = 50
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  inValid,
  output logic                  inReady,
  output logic                  outValid,
  input  logic                  outReady,
  input  logic                  pctWrEn,
  input  logic                  pctWrSel,
  input  logic [CFG_W-1:0]      pctWrData,
  output mixStrobes_t           strobes,
  output logic [1:0][PCT_W-1:0] pctCfg
);
  mixState_t state, stateNext;
  logic [PCT_W-1:0] pctClamped;

  always_comb begin
    pctClamped = (pctWrData > CFG_W'(PCT_MAX)) ? PCT_W'(PCT_MAX) : pctWrData[PCT_W-1:0];
  end

  genvar ch;
  generate
    for (ch = 0; ch < 2; ch++) begin : g_pct
      always_ff @(posedge clk) begin
        if (!rstN)
          pctCfg[ch] <= PCT_W'(PCT_UNITY);
        else if (pctWrEn && (pctWrSel == ch[0]))
          pctCfg[ch] <= pctClamped;
      end

      p_pct_range_r7: assert property (@(posedge clk) disable iff (!rstN)
        pctCfg[ch] <= PCT_W'(PCT_MAX));
    end
  endgenerate

  always_comb begin
    inReady  = (state == ST_FIRST) || (state == ST_SECOND);
    outValid = (state == ST_EMIT_L) || (state == ST_EMIT_R);
    strobes.takeFirst  = (state == ST_FIRST)  && inValid;
    strobes.takeSecond = (state == ST_SECOND) && inValid;
    stateNext = state;
    case (state)
      ST_FIRST:  if (inValid)  stateNext = ST_SECOND;
      ST_SECOND: if (inValid)  stateNext = ST_EMIT_L;
      ST_EMIT_L: if (outReady) stateNext = ST_EMIT_R;
      ST_EMIT_R: if (outReady) stateNext = ST_FIRST;
      default:                 stateNext = ST_FIRST;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_FIRST;
    else       state <= stateNext;
  end

  p_hold_valid_r6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid);

  p_latency_r9: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && !strobes.takeFirst) |=> outValid);
endmodule

// File: rtl/mix_datapath.sv
module mix_datapath
  import mixer_pkg::*;
#(
  parameter int SAMPLE_W  = 16,
  parameter int PCT_W     = 7,
  parameter int PCT_UNITY = 50
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  mixStrobes_t           strobes,
  input  logic [SAMPLE_W-1:0]   inData,
  input  logic [1:0][PCT_W-1:0] pctCfg,
  output logic [SAMPLE_W-1:0]   mixOut
);
  localparam int SUM_W  = SAMPLE_W + 1;
  localparam int PROD_W = 2 * SAMPLE_W;
  localparam logic [SUM_W-1:0] FULL = SUM_W'({SAMPLE_W{1'b1}});

  logic [SAMPLE_W-1:0]   firstRaw;
  logic [1:0][PCT_W-1:0] activePct;
  logic [1:0][SAMPLE_W-1:0] rawIn;
  logic [1:0][SAMPLE_W-1:0] scaled;
  logic [SUM_W-1:0]      sumAB;
  logic [PROD_W-1:0]     crossProd;
  logic [SUM_W-1:0]      diff;
  logic [SAMPLE_W-1:0]   mixNext;

  assign rawIn[0] = firstRaw;
  assign rawIn[1] = inData;

  genvar ch;
  generate
    for (ch = 0; ch < 2; ch++) begin : g_scale
      mix_scaler #(
        .SAMPLE_W (SAMPLE_W),
        .PCT_W    (PCT_W),
        .PCT_UNITY(PCT_UNITY)
      ) u_scaler (
        .sampleIn (rawIn[ch]),
        .pctIn    (activePct[ch]),
        .scaledOut(scaled[ch])
      );
    end
  endgenerate

  always_comb begin
    sumAB     = SUM_W'(scaled[0]) + SUM_W'(scaled[1]);
    crossProd = PROD_W'(scaled[0]) * PROD_W'(scaled[1]);
    diff      = sumAB - SUM_W'(crossProd >> SAMPLE_W);
    mixNext   = (diff > FULL) ? {SAMPLE_W{1'b1}} : diff[SAMPLE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      firstRaw  <= '0;
      activePct <= {PCT_W'(PCT_UNITY), PCT_W'(PCT_UNITY)};
      mixOut    <= '0;
    end else begin
      if (strobes.takeFirst) begin
        firstRaw  <= inData;
        activePct <= pctCfg;
      end
      if (strobes.takeSecond)
        mixOut <= mixNext;
    end
  end

  p_mix_floor_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.takeSecond |=> (mixOut >= $past(scaled[0])) && (mixOut >= $past(scaled[1])));
endmodule

// File: rtl/ratio_audio_mixer.sv
module ratio_audio_mixer
  import mixer_pkg::*;
#(
  parameter int SAMPLE_W  = 16,
  parameter int PCT_W     = 7,
  parameter int CFG_W     = 8,
  parameter int PCT_MAX   = 100,
  parameter int PCT_UNITY = 50
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SAMPLE_W-1:0] inData,
  input  logic                inValid,
  output logic                inReady,
  output logic [SAMPLE_W-1:0] outData,
  output logic                outValid,
  input  logic                outReady,
  input  logic                pctWrEn,
  input  logic                pctWrSel,
  input  logic [CFG_W-1:0]    pctWrData
);
  mixStrobes_t           strobes;
  logic [1:0][PCT_W-1:0] pctCfg;

  mix_control #(
    .PCT_W    (PCT_W),
    .CFG_W    (CFG_W),
    .PCT_MAX  (PCT_MAX),
    .PCT_UNITY(PCT_UNITY)
  ) u_control (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inReady  (inReady),
    .outValid (outValid),
    .outReady (outReady),
    .pctWrEn  (pctWrEn),
    .pctWrSel (pctWrSel),
    .pctWrData(pctWrData),
    .strobes  (strobes),
    .pctCfg   (pctCfg)
  );

  mix_datapath #(
    .SAMPLE_W (SAMPLE_W),
    .PCT_W    (PCT_W),
    .PCT_UNITY(PCT_UNITY)
  ) u_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .inData (inData),
    .pctCfg (pctCfg),
    .mixOut (outData)
  );

  p_pair_same_r5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(outValid)) |-> $stable(outData));

  p_no_intake_r6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> !inReady);
endmodule

// File: tb/ratio_audio_mixer_test.sv
module ratio_audio_mixer_test;
  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] inData;
  logic        inValid;
  logic        inReady;
  logic [15:0] outData;
  logic        outValid;
  logic        outReady;
  logic        pctWrEn;
  logic        pctWrSel;
  logic [7:0]  pctWrData;

  int checks = 0;
  int fails  = 0;
  int curP1  = 50;
  int curP2  = 50;

  always #5 clk = ~clk;

  ratio_audio_mixer uut (
    .clk(clk), .rstN(rstN), .inData(inData), .inValid(inValid), .inReady(inReady),
    .outData(outData), .outValid(outValid), .outReady(outReady),
    .pctWrEn(pctWrEn), .pctWrSel(pctWrSel), .pctWrData(pctWrData)
  );

  function automatic int scaleRef(int s, int p);
    int v = (s * p) / 50;
    return (v > 65535) ? 65535 : v;
  endfunction

  function automatic int mixRef(int a, int b);
    longint v = longint'(a) + longint'(b) - ((longint'(a) * longint'(b)) >>> 16);
    return (v > 65535) ? 65535 : int'(v);
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic writePct(int sel, int val);
    pctWrEn = 1'b1; pctWrSel = sel[0]; pctWrData = val[7:0];
    @(posedge clk); @(negedge clk);
    pctWrEn = 1'b0;
    if (sel == 0) curP1 = (val > 100) ? 100 : val;
    else          curP2 = (val > 100) ? 100 : val;
  endtask

  task automatic sendWord(int d);
    inValid = 1'b1; inData = d[15:0];
    while (!inReady) @(negedge clk);
    @(posedge clk); @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic recvWord(output int d, input int stallMax, input string tag);
    int waitN = $urandom_range(stallMax, 0);
    int held  = 0;
    outReady = 1'b0;
    repeat (waitN) begin
      if (outValid) begin
        if (held == 0) held = int'(outData);
        else check(int'(outData) == held, {tag, " R6 data held"}, int'(outData), held);
        check(!inReady, {tag, " R6 no intake while pending"}, int'(inReady), 0);
      end
      @(negedge clk);
    end
    outReady = 1'b1;
    while (!outValid) @(negedge clk);
    d = int'(outData);
    @(posedge clk); @(negedge clk);
    outReady = 1'b0;
  endtask

  task automatic runFrame(int a, int b, int stallMax, int midSel, int midVal, string tag);
    int exp = mixRef(scaleRef(a, curP1), scaleRef(b, curP2));
    int w0, w1;
    sendWord(a);
    check(!outValid, {tag, " R2 no output after first word"}, int'(outValid), 0);
    if (midSel >= 0) writePct(midSel, midVal);
    sendWord(b);
    check(outValid, {tag, " R9 valid right after second word"}, int'(outValid), 1);
    recvWord(w0, stallMax, tag);
    check(w0 == exp, {tag, " R4 left word"}, w0, exp);
    recvWord(w1, stallMax, tag);
    check(w1 == exp, {tag, " R5 right word equals left"}, w1, exp);
    check(!outValid && inReady, {tag, " R5 exactly two words"}, int'(outValid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rstN = 1'b0; inValid = 1'b0; inData = '0; outReady = 1'b0;
    pctWrEn = 1'b0; pctWrSel = 1'b0; pctWrData = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    check(!outValid, "R1 outValid low after reset", int'(outValid), 0);
    check(inReady, "R1 inReady high after reset", int'(inReady), 1);

    // R1: default unity gain
    runFrame(30000, 20000, 0, -1, 0, "R1 default");
    // R4: both full scale clamps 65536 down
    runFrame(65535, 65535, 2, -1, 0, "R4 fullscale");
    runFrame(0, 12345, 1, -1, 0, "R4 zero side");
    // R3: boost overflow clamps, attenuation truncates
    writePct(0, 100); writePct(1, 25);
    runFrame(40000, 40001, 1, -1, 0, "R3 boost+atten");
    writePct(0, 0); writePct(1, 0);
    runFrame(65535, 65535, 0, -1, 0, "R3 zero pct");
    // R7: 200 stored as 100
    writePct(0, 200);
    runFrame(1000, 777, 0, -1, 0, "R7 clamp write");
    // R8: write between the two words does not touch this frame
    writePct(0, 50); writePct(1, 50);
    runFrame(20000, 10000, 0, 1, 10, "R8 mid-frame");
    runFrame(20000, 10000, 0, -1, 0, "R8 next frame");
    // R6: long backpressure
    runFrame(50000, 45000, 8, -1, 0, "R6 stall");

    // random traffic with random gain changes
    for (int i = 0; i < 40; i++) begin
      if ($urandom_range(3, 0) == 0) writePct(int'($urandom_range(1, 0)), int'($urandom_range(130, 0)));
      runFrame(int'($urandom_range(65535, 0)), int'($urandom_range(65535, 0)),
               int'($urandom_range(4, 0)), -1, 0, "R3 R4 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule